// File: doc/BRIEF.md
# Serial-controlled audio settings register

This block is the digital control front end of an audio processor with a volume stage, a balance stage, a five-band equalizer and an input selector. A host sends command frames over three plain pins: a chip enable (`ce`), a serial clock (`sclk`) and serial data (`sdi`). A fast system clock samples all three pins. The analog attenuators, filters and switches sit outside this block and take its decoded control fields as static settings.

A frame has two parts. First come 8 address bits, shifted in while `ce` is low. Then come 40 data bits, shifted in while `ce` is high. Nothing is applied until `ce` falls. At that moment the block checks the frame. If the frame is accepted, all the settings it carries are written into the output register bank together.

The four volume channels can be updated selectively. Each frame carries one volume code, and separate side bits and position bits choose which of the four channels load it. Because this is a static control interface, none of the pins has back-pressure or a handshake. The host must keep to the serial timing, which is a bit period of at least a few system clocks.

Top module: `audctl_top`

## Requirements
- R1: A frame is applied only if three things hold when `ce` falls: the address equals 0x41, exactly 40 data bits were clocked, and the two test bits D38 and D39 are both 0. Any other frame is discarded, and no output changes.
- R2: Bits are taken on rising `sclk` edges. While `ce` is low the last 8 bits form the address, with the first of them as address bit 0. While `ce` is high the bits fill the data word, with the first bit as D0 and the last as D39.
- R3: Outputs change only as a result of an accepted frame at a falling `ce`. While data bits are being shifted in, every output holds its earlier value.
- R4: After reset, the outputs take these values: `in_sel` = 0, both fifth-input enables off, every equalizer band = 5 (flat), every volume = 80 (mute), and `chan_mode` = 0.
- R5: Bits D2..D0 form the selector code. Codes 0 to 4 pick inputs 1 to 5 and are loaded. Codes 5 to 7 leave `in_sel` unchanged. D3 drives `in5_l_on` and D4 drives `in5_r_on`.
- R6: Equalizer band k (k = 0 to 4) is the 4-bit field D(8+4k)..D(5+4k), with its LSB at D(5+4k). Code c means a gain of 2c-10 dB. Codes 0 to 10 are loaded; codes 11 to 15 leave that band unchanged. Band k appears on `eq_codes[4k+3:4k]`.
- R7: Bits D31..D25 form the volume code, which is an attenuation in dB. Codes 0 to 79 are stored as sent. Any code of 80 or more is stored as 80, which means minus infinity (mute).
- R8: D33 enables the left side, D32 the right side, D36 the front channels and D37 the rear channels. A volume channel loads the frame's volume code only when both its side bit and its position bit are 1.
- R9: Every accepted frame copies D35..D34 to `chan_mode[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable pin: low for the address, high for data, falling edge applies the frame |
| sclk | input | 1 | Serial clock pin, sampled on rising edges |
| sdi | input | 1 | Serial data pin |
| in_sel | output | 3 | Selected input code, 0 to 4 |
| in5_l_on | output | 1 | Left fifth input switched on |
| in5_r_on | output | 1 | Right fifth input switched on |
| eq_codes | output | 20 | Five 4-bit equalizer band codes, band k at [4k+3:4k] |
| vol_lf | output | 7 | Left front attenuation code |
| vol_lr | output | 7 | Left rear attenuation code |
| vol_rf | output | 7 | Right front attenuation code |
| vol_rr | output | 7 | Right rear attenuation code |
| chan_mode | output | 2 | Channel-setup mode bits |

## Verification
Directed frames cover each rejection cause on its own: a bit-reversed address, 39 data bits, 41 data bits, and nonzero test bits. Each of these must leave every output untouched, which separates a correct acceptance check from one that tests only part of the frame. Boundary codes tell clamping apart from pass-through and from rejection: volume 79, 80 and 127, equalizer 10, 11 and 15, and selector 4 and 5. All four combinations of side and position enables are sent so that each channel's load gating shows up separately. A seeded random run then mixes good and bad addresses, bit counts near 40 and random data words against a bench model. A mid-frame comparison confirms that outputs hold until `ce` falls.

// File: rtl/audctl_pkg.sv
`timescale 1ns/1ps
package audctl_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 40;
  localparam int N_BANDS   = 5;
  localparam int EQ_W      = 4;
  localparam int VOL_W     = 7;
  localparam int SEL_W     = 3;
  localparam int MODE_W    = 2;
  localparam int N_VOL     = 4;

  // data-word field positions (D0 is the first data bit on the wire)
  localparam int SEL_LSB   = 0;
  localparam int IN5L_BIT  = 3;
  localparam int IN5R_BIT  = 4;
  localparam int EQ_LSB    = 5;
  localparam int VOL_LSB   = EQ_LSB + N_BANDS * EQ_W;
  localparam int R_EN_BIT  = 32;
  localparam int L_EN_BIT  = 33;
  localparam int MODE_LSB  = 34;
  localparam int FRONT_BIT = 36;
  localparam int REAR_BIT  = 37;
  localparam int TEST_LSB  = 38;
  localparam int CFG_W     = TEST_LSB;

  localparam int SEL_MAX   = 4;
  localparam int EQ_MAX    = 10;
  localparam int EQ_FLAT   = 5;
  localparam int VOL_MUTE  = 80;

  localparam logic [ADDR_W-1:0] DEV_ADDR = 8'h41;

  typedef logic [VOL_W-1:0] vol_t;
  typedef logic [EQ_W-1:0]  eq_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/audctl_sync.sv
`timescale 1ns/1ps
module audctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/audctl_rx.sv
`timescale 1ns/1ps
module audctl_rx
  import audctl_pkg::*;
#(
  parameter int                ADW  = ADDR_W,
  parameter int                DW   = DATA_W,
  parameter int                OUTW = CFG_W,
  parameter logic [ADW-1:0]    MY_ADDR = DEV_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_s,
  input  logic            sclk_s,
  input  logic            sdi_s,
  output logic            frame_stb,
  output logic [OUTW-1:0] frame_data
);
  localparam int CNT_W = $clog2(DW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DW + 1);

  logic             ce_d, sclk_d;
  logic [ADW-1:0]   addr_sr;
  logic [DW-1:0]    data_sr;
  logic [CNT_W-1:0] bit_cnt;
  logic             sclk_rise, ce_rise, ce_fall;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign ce_rise   = ce_s & ~ce_d;
  assign ce_fall   = ce_d & ~ce_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d    <= 1'b0;
      sclk_d  <= 1'b0;
      addr_sr <= '0;
      data_sr <= '0;
      bit_cnt <= '0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
      if (sclk_rise) begin
        if (ce_s) begin
          data_sr <= {sdi_s, data_sr[DW-1:1]};
          if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end else begin
          addr_sr <= {sdi_s, addr_sr[ADW-1:1]};
        end
      end
      if (ce_rise) bit_cnt <= '0;
    end
  end

  assign frame_stb  = ce_fall && (addr_sr == MY_ADDR) && (bit_cnt == CNT_FULL)
                      && (data_sr[DW-1:OUTW] == '0);
  assign frame_data = data_sr[OUTW-1:0];
endmodule

// File: rtl/audctl_regs.sv
`timescale 1ns/1ps
module audctl_regs
  import audctl_pkg::*;
#(
  parameter int NB = N_BANDS,
  parameter int NV = N_VOL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_stb,
  input  logic [CFG_W-1:0]      frame_data,
  output sel_t                  in_sel,
  output logic                  in5_l_on,
  output logic                  in5_r_on,
  output logic [NB*EQ_W-1:0]    eq_codes,
  output logic [NV*VOL_W-1:0]   vol_codes,
  output logic [MODE_W-1:0]     chan_mode
);
  sel_t sel_raw;
  vol_t vol_raw, vol_norm;

  assign sel_raw  = frame_data[SEL_LSB +: SEL_W];
  assign vol_raw  = frame_data[VOL_LSB +: VOL_W];
  assign vol_norm = (vol_raw >= vol_t'(VOL_MUTE)) ? vol_t'(VOL_MUTE) : vol_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sel    <= '0;
      in5_l_on  <= 1'b0;
      in5_r_on  <= 1'b0;
      chan_mode <= '0;
    end else if (frame_stb) begin
      if (sel_raw <= sel_t'(SEL_MAX)) in_sel <= sel_raw;
      in5_l_on  <= frame_data[IN5L_BIT];
      in5_r_on  <= frame_data[IN5R_BIT];
      chan_mode <= frame_data[MODE_LSB +: MODE_W];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_band
    eq_t code_q;
    eq_t code_in;
    assign code_in = frame_data[EQ_LSB + b*EQ_W +: EQ_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     code_q <= eq_t'(EQ_FLAT);
      else if (frame_stb && code_in <= eq_t'(EQ_MAX)) code_q <= code_in;
    end
    assign eq_codes[b*EQ_W +: EQ_W] = code_q;
  end

  // channel index: 0 left front, 1 left rear, 2 right front, 3 right rear
  for (genvar c = 0; c < NV; c++) begin : g_vol
    localparam int SIDE_BIT = (c < NV/2) ? L_EN_BIT : R_EN_BIT;
    localparam int POS_BIT  = (c % 2 == 0) ? FRONT_BIT : REAR_BIT;
    vol_t vol_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vol_q <= vol_t'(VOL_MUTE);
      else if (frame_stb && frame_data[SIDE_BIT] && frame_data[POS_BIT])
        vol_q <= vol_norm;
    end
    assign vol_codes[c*VOL_W +: VOL_W] = vol_q;
  end
endmodule

// File: rtl/audctl_top.sv
`timescale 1ns/1ps
module audctl_top
  import audctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic [SEL_W-1:0]        in_sel,
  output logic                    in5_l_on,
  output logic                    in5_r_on,
  output logic [N_BANDS*EQ_W-1:0] eq_codes,
  output logic [VOL_W-1:0]        vol_lf,
  output logic [VOL_W-1:0]        vol_lr,
  output logic [VOL_W-1:0]        vol_rf,
  output logic [VOL_W-1:0]        vol_rr,
  output logic [MODE_W-1:0]       chan_mode
);
  logic [2:0]             pins_s;
  logic                   frame_stb;
  logic [CFG_W-1:0]       frame_data;
  logic [N_VOL*VOL_W-1:0] vol_codes;

  audctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({ce, sclk, sdi}), .q (pins_s)
  );

  audctl_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (pins_s[2]),
    .sclk_s     (pins_s[1]),
    .sdi_s      (pins_s[0]),
    .frame_stb  (frame_stb),
    .frame_data (frame_data)
  );

  audctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .frame_data (frame_data),
    .in_sel     (in_sel),
    .in5_l_on   (in5_l_on),
    .in5_r_on   (in5_r_on),
    .eq_codes   (eq_codes),
    .vol_codes  (vol_codes),
    .chan_mode  (chan_mode)
  );

  assign vol_lf = vol_codes[0*VOL_W +: VOL_W];
  assign vol_lr = vol_codes[1*VOL_W +: VOL_W];
  assign vol_rf = vol_codes[2*VOL_W +: VOL_W];
  assign vol_rr = vol_codes[3*VOL_W +: VOL_W];
endmodule

// File: rtl/audctl_chk.sv
`timescale 1ns/1ps
module audctl_chk
  import audctl_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_stb,
  input logic [CFG_W-1:0]        frame_data,
  input logic [SEL_W-1:0]        in_sel,
  input logic                    in5_l_on,
  input logic                    in5_r_on,
  input logic [N_BANDS*EQ_W-1:0] eq_codes,
  input logic [VOL_W-1:0]        vol_lf,
  input logic [VOL_W-1:0]        vol_lr,
  input logic [VOL_W-1:0]        vol_rf,
  input logic [VOL_W-1:0]        vol_rr,
  input logic [MODE_W-1:0]       chan_mode
);
  AST_HOLD_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> $stable({in_sel, in5_l_on, in5_r_on, eq_codes,
                                   vol_lf, vol_lr, vol_rf, vol_rr, chan_mode})); // R3

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel <= SEL_W'(SEL_MAX)); // R5

  AST_VOL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_lf <= VOL_W'(VOL_MUTE)) && (vol_lr <= VOL_W'(VOL_MUTE)) &&
    (vol_rf <= VOL_W'(VOL_MUTE)) && (vol_rr <= VOL_W'(VOL_MUTE))); // R7

  for (genvar b = 0; b < N_BANDS; b++) begin : g_eq_chk
    AST_EQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      eq_codes[b*EQ_W +: EQ_W] <= EQ_W'(EQ_MAX)); // R6
  end

  AST_LEFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_stb) && !$past(frame_data[L_EN_BIT])) |->
      ($stable(vol_lf) && $stable(vol_lr))); // R8

  AST_RIGHT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_stb) && !$past(frame_data[R_EN_BIT])) |->
      ($stable(vol_rf) && $stable(vol_rr))); // R8

  AST_MODE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_stb) |-> (chan_mode == $past(frame_data[MODE_LSB +: MODE_W]))); // R9
endmodule

bind audctl_top audctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_stb  (frame_stb),
  .frame_data (frame_data),
  .in_sel     (in_sel),
  .in5_l_on   (in5_l_on),
  .in5_r_on   (in5_r_on),
  .eq_codes   (eq_codes),
  .vol_lf     (vol_lf),
  .vol_lr     (vol_lr),
  .vol_rf     (vol_rf),
  .vol_rr     (vol_rr),
  .chan_mode  (chan_mode)
);

// File: tb/test_audctl_top.sv
`timescale 1ns/1ps
module test_audctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [2:0]  in_sel;
  logic        in5_l_on, in5_r_on;
  logic [19:0] eq_codes;
  logic [6:0]  vol_lf, vol_lr, vol_rf, vol_rr;
  logic [1:0]  chan_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_sel, m_l5, m_r5, m_mode;
  int m_eq [5];
  int m_vol [4];

  always #2.5 clk = ~clk;

  audctl_top i_audctl_top (
    .clk (clk), .rst_n (rst_n), .ce (ce), .sclk (sclk), .sdi (sdi),
    .in_sel (in_sel), .in5_l_on (in5_l_on), .in5_r_on (in5_r_on),
    .eq_codes (eq_codes), .vol_lf (vol_lf), .vol_lr (vol_lr),
    .vol_rf (vol_rf), .vol_rr (vol_rr), .chan_mode (chan_mode)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_l5 = 0; m_r5 = 0; m_mode = 0;
    for (int b = 0; b < 5; b++) m_eq[b] = 5;
    for (int c = 0; c < 4; c++) m_vol[c] = 80;
  endtask

  task automatic model_apply(logic [39:0] d);
    int v;
    if (d[2:0] <= 3'd4) m_sel = int'(d[2:0]);
    m_l5 = int'(d[3]);
    m_r5 = int'(d[4]);
    for (int b = 0; b < 5; b++)
      if (d[5+4*b +: 4] <= 4'd10) m_eq[b] = int'(d[5+4*b +: 4]);
    v = int'(d[31:25]);
    if (v > 80) v = 80;
    if (d[33] && d[36]) m_vol[0] = v;
    if (d[33] && d[37]) m_vol[1] = v;
    if (d[32] && d[36]) m_vol[2] = v;
    if (d[32] && d[37]) m_vol[3] = v;
    m_mode = int'(d[35:34]);
  endtask

  task automatic compare_all(string req);
    chk(req, "in_sel", int'(in_sel), m_sel);
    chk(req, "in5_l_on", int'(in5_l_on), m_l5);
    chk(req, "in5_r_on", int'(in5_r_on), m_r5);
    for (int b = 0; b < 5; b++) chk(req, $sformatf("eq band %0d", b), int'(eq_codes[4*b +: 4]), m_eq[b]);
    chk(req, "vol_lf", int'(vol_lf), m_vol[0]);
    chk(req, "vol_lr", int'(vol_lr), m_vol[1]);
    chk(req, "vol_rf", int'(vol_rf), m_vol[2]);
    chk(req, "vol_rr", int'(vol_rr), m_vol[3]);
    chk(req, "chan_mode", int'(chan_mode), m_mode);
  endtask

  // eq packed as {b4,b3,b2,b1,b0}; side bit1 left, bit0 right; pos bit0 front, bit1 rear
  function automatic logic [39:0] mk(int sel, int in5, logic [19:0] eq, int vol,
                                     int side, int pos, int mode, int tst);
    logic [39:0] d = '0;
    d[2:0]   = 3'(sel);
    d[3]     = in5[0];
    d[4]     = in5[1];
    d[24:5]  = eq;
    d[31:25] = 7'(vol);
    d[32]    = side[0];
    d[33]    = side[1];
    d[35:34] = 2'(mode);
    d[36]    = pos[0];
    d[37]    = pos[1];
    d[39:38] = 2'(tst);
    return d;
  endfunction

  task automatic send_bit(logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] a, logic [39:0] d, int nbits, string req);
    @(negedge clk);
    ce = 1'b0;
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    repeat (4) @(negedge clk);
    ce = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) send_bit(i < 40 ? d[i] : 1'b0);
    repeat (6) @(negedge clk);
    compare_all("R3");
    ce = 1'b0;
    repeat (12) @(negedge clk);
    if (a == 8'h41 && nbits == 40 && d[39:38] == 2'b00) model_apply(d);
    compare_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] d;
    logic [7:0]  a;
    int          nb, r;
    void'($urandom(32'd5150));
    model_reset();
    repeat (5) @(negedge clk);
    compare_all("R4");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    compare_all("R4");

    // R1 / R2: a full valid frame with distinct field values
    send_frame(8'h41, mk(2, 3, {4'd7, 4'd3, 4'd5, 4'd10, 4'd0}, 12, 3, 3, 2, 0), 40, "R1");
    // R1: rejections
    send_frame(8'h82, mk(1, 0, 20'h0, 5, 3, 3, 1, 0), 40, "R1");
    send_frame(8'h41, mk(1, 0, 20'h0, 5, 3, 3, 1, 0), 39, "R1");
    send_frame(8'h41, mk(1, 0, 20'h0, 5, 3, 3, 1, 0), 41, "R1");
    send_frame(8'h41, mk(1, 0, 20'h0, 5, 3, 3, 1, 2), 40, "R1");
    // R7: volume boundaries
    send_frame(8'h41, mk(0, 0, 20'h55555, 79, 3, 3, 0, 0), 40, "R7");
    send_frame(8'h41, mk(0, 0, 20'h55555, 127, 3, 3, 0, 0), 40, "R7");
    send_frame(8'h41, mk(0, 0, 20'h55555, 0, 3, 3, 0, 0), 40, "R7");
    send_frame(8'h41, mk(0, 0, 20'h55555, 80, 3, 3, 0, 0), 40, "R7");
    // R8: enable combinations
    send_frame(8'h41, mk(0, 0, 20'h55555, 33, 2, 1, 0, 0), 40, "R8");
    send_frame(8'h41, mk(0, 0, 20'h55555, 44, 1, 2, 0, 0), 40, "R8");
    send_frame(8'h41, mk(0, 0, 20'h55555, 9, 0, 3, 0, 0), 40, "R8");
    send_frame(8'h41, mk(0, 0, 20'h55555, 9, 3, 0, 0, 0), 40, "R8");
    send_frame(8'h41, mk(0, 0, 20'h55555, 21, 2, 2, 0, 0), 40, "R8");
    // R5: selector limits and fifth-input bits
    send_frame(8'h41, mk(4, 1, 20'h55555, 0, 0, 0, 0, 0), 40, "R5");
    send_frame(8'h41, mk(5, 2, 20'h55555, 0, 0, 0, 0, 0), 40, "R5");
    send_frame(8'h41, mk(7, 0, 20'h55555, 0, 0, 0, 0, 0), 40, "R5");
    // R6: equalizer limits
    send_frame(8'h41, mk(1, 0, {4'd10, 4'd0, 4'd9, 4'd1, 4'd10}, 0, 0, 0, 0, 0), 40, "R6");
    send_frame(8'h41, mk(1, 0, {4'd11, 4'd15, 4'd2, 4'd12, 4'd4}, 0, 0, 0, 0, 0), 40, "R6");
    // R9: mode bits
    send_frame(8'h41, mk(1, 0, 20'h55555, 0, 0, 0, 1, 0), 40, "R9");
    send_frame(8'h41, mk(1, 0, 20'h55555, 0, 0, 0, 3, 0), 40, "R9");

    // R2: seeded random frames
    for (int k = 0; k < 40; k++) begin
      r  = int'($urandom_range(0, 9));
      a  = (r < 8) ? 8'h41 : 8'($urandom);
      r  = int'($urandom_range(0, 9));
      nb = (r < 8) ? 40 : int'($urandom_range(38, 42));
      d  = {8'($urandom), 32'($urandom)};
      if ($urandom_range(0, 3) != 0) d[39:38] = 2'b00;
      send_frame(a, d, nb, "R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule